// File: doc/BRIEF.md
# Front panel jump-injection sequencer

This block moves a halted 8-bit processor to an address chosen on sixteen panel switches. It does not drive the address bus or create any memory cycles. When a debounced examine pulse arrives while the bus is quiet, the block raises the processor's ready line. It then answers the next three read cycles with bytes it makes up itself: an unconditional jump opcode, the low address byte, and the high address byte. Once the third read has finished, it drops ready and the processor stops again, now at the chosen address. The processor's own fetch of the jump operands does all of the memory addressing.

Any address the processor puts out during these reads is not used. Every read inside the sequence gets the injected byte. A data line that is not forced low reads as one, as if a pull-up held it. A panel switch that is turned on forces its bit to zero. The opcode is made the same way: bits 2 to 5 are forced low and the other bits stay high.

Top module: `fp_jump_injector`

## Requirements
- R1: After reset, `ready_o` and `exam_line_o` are 0, `inj_valid_o` is 0 and `inj_data_o` is 0xFF.
- R2: An examine pulse sampled while the sequence is idle and `rd_strobe_i` is low sets `ready_o` and `exam_line_o` to 1 at the next clock edge.
- R3: An examine pulse sampled while idle but with `rd_strobe_i` high (bus busy) is ignored, and `ready_o` stays 0.
- R4: The first read cycle of a sequence receives 0xC3 (bits 2, 3, 4 and 5 are zero, bits 0, 1, 6 and 7 are one).
- R5: The second read cycle receives the bitwise inverse of `addr_sw_i[7:0]`: a switch at 1 gives a 0 bit.
- R6: The third read cycle receives the bitwise inverse of `addr_sw_i[15:8]`.
- R7: The sequence advances by one step per falling edge of `rd_strobe_i`. A strobe held high for several cycles keeps the same byte.
- R8: The edge that registers the falling edge of the third read clears `ready_o` and `exam_line_o` together. Later reads get 0xFF with `inj_valid_o` at 0.
- R9: `inj_valid_o` is 1 exactly one clock after a cycle in which `rd_strobe_i` is high and a sequence is active. At every other time `inj_data_o` is 0xFF.
- R10: An examine pulse that arrives during a sequence is ignored: the remaining bytes and `ready_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exam_pulse_i | input | 1 | Debounced examine request, one cycle wide |
| addr_sw_i | input | 16 | Address switches, 1 = switch on (forces the bit low) |
| rd_strobe_i | input | 1 | Processor read strobe, high during a read cycle |
| ready_o | output | 1 | Ready line to the processor, high while the sequence runs |
| exam_line_o | output | 1 | Examine line, high while the sequence runs |
| inj_data_o | output | 8 | Injected byte, 0xFF when released |
| inj_valid_o | output | 1 | Injected byte is being driven |

## Verification
Every output comes from a register, so each result is due at the first rising edge after the input that causes it. `ready_o` follows an accepted examine pulse one edge later. An injected byte appears one edge after the strobe rises, and it is released one edge after the strobe falls. The bench drives inputs just after a falling clock edge and samples at the following falling edge, which puts each sample exactly one register stage after its stimulus. A driver queues the byte each read should get, and a monitor pops that byte when `inj_valid_o` rises and compares it with `inj_data_o`.

// File: rtl/fpj_pkg.sv
package fpj_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_ADDR_W = 16;
  // Bits the injector pulls low to form the jump opcode (0xFF & ~0x3C = 0xC3)
  localparam logic [7:0] DEF_OPC_LOW_MASK = 8'h3C;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_OPCODE = 2'd1,
    PH_ADDR   = 2'd2
  } phase_t;
endpackage

// File: rtl/fpj_strobe_edge.sv
module fpj_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  output logic rd_level,
  output logic rd_fall
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_i;
  end

  assign rd_level = rd_i;
  assign rd_fall  = rd_q & ~rd_i;
endmodule

// File: rtl/fpj_step_ctr.sv
module fpj_step_ctr
  import fpj_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             rd_level,
  input  logic             rd_fall,
  output phase_t           phase,
  output logic [IDX_W-1:0] byte_idx,
  output logic             run_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  phase_t           phase_n;
  logic [IDX_W-1:0] idx_n;

  always_comb begin
    phase_n = phase;
    idx_n   = byte_idx;
    unique case (phase)
      PH_IDLE: begin
        if (start_req && !rd_level) begin
          phase_n = PH_OPCODE;
          idx_n   = '0;
        end
      end
      PH_OPCODE: begin
        if (rd_fall) begin
          phase_n = PH_ADDR;
          idx_n   = '0;
        end
      end
      PH_ADDR: begin
        if (rd_fall) begin
          if (byte_idx == LAST_IDX) begin
            phase_n = PH_IDLE;
            idx_n   = '0;
          end else begin
            idx_n = byte_idx + 1'b1;
          end
        end
      end
      default: begin
        phase_n = PH_IDLE;
        idx_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      byte_idx <= '0;
      run_q    <= 1'b0;
    end else begin
      phase    <= phase_n;
      byte_idx <= idx_n;
      run_q    <= (phase_n != PH_IDLE);
    end
  end

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start_req && !rd_level) |=> run_q);

  // R3
  busy_bus_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start_req && rd_level) |=> (phase == PH_IDLE && !run_q));

  // R7 R10
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !rd_fall) |=> ($stable(phase) && $stable(byte_idx)));

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR && byte_idx == LAST_IDX && rd_fall) |=> (!run_q && phase == PH_IDLE));
endmodule

// File: rtl/fpj_byte_drive.sv
module fpj_byte_drive
  import fpj_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              ADDR_W      = 16,
  parameter logic [DATA_W-1:0] OPC_LOW_MASK = DATA_W'(8'h3C),
  localparam int ADDR_BYTES = ADDR_W / DATA_W,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic              rd_level,
  input  logic [ADDR_W-1:0] sw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam logic [DATA_W-1:0] RELEASED = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] OPCODE   = RELEASED & ~OPC_LOW_MASK;

  logic [DATA_W-1:0] sw_byte [ADDR_BYTES];
  logic [DATA_W-1:0] addr_byte;
  logic [DATA_W-1:0] pick;
  logic              drive;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_slice
    // An "on" switch pulls its line low; an untouched line stays high
    assign sw_byte[g] = RELEASED & ~sw_i[g*DATA_W +: DATA_W];
  end

  assign addr_byte = sw_byte[byte_idx];
  assign drive     = rd_level && (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_OPCODE: pick = OPCODE;
      PH_ADDR:   pick = addr_byte;
      default:   pick = RELEASED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= RELEASED;
      valid_o <= 1'b0;
    end else begin
      data_o  <= drive ? pick : RELEASED;
      valid_o <= drive;
    end
  end

  // R9
  released_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (data_o == RELEASED));

  // R4
  opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPCODE && rd_level) |=> (valid_o && data_o == OPCODE));
endmodule

// File: rtl/fp_jump_injector.sv
module fp_jump_injector
  import fpj_pkg::*;
#(
  parameter int                DATA_W       = DEF_DATA_W,
  parameter int                ADDR_W       = DEF_ADDR_W,
  parameter logic [DATA_W-1:0] OPC_LOW_MASK = DATA_W'(DEF_OPC_LOW_MASK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exam_pulse_i,
  input  logic [ADDR_W-1:0] addr_sw_i,
  input  logic              rd_strobe_i,
  output logic              ready_o,
  output logic              exam_line_o,
  output logic [DATA_W-1:0] inj_data_o,
  output logic              inj_valid_o
);
  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic             rd_level;
  logic             rd_fall;
  phase_t           phase;
  logic [IDX_W-1:0] byte_idx;
  logic             run_q;

  fpj_strobe_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (rd_strobe_i),
    .rd_level (rd_level),
    .rd_fall  (rd_fall)
  );

  fpj_step_ctr #(.ADDR_BYTES(ADDR_BYTES)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .start_req (exam_pulse_i),
    .rd_level  (rd_level),
    .rd_fall   (rd_fall),
    .phase     (phase),
    .byte_idx  (byte_idx),
    .run_q     (run_q)
  );

  fpj_byte_drive #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .OPC_LOW_MASK (OPC_LOW_MASK)
  ) u_drive (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .byte_idx (byte_idx),
    .rd_level (rd_level),
    .sw_i     (addr_sw_i),
    .data_o   (inj_data_o),
    .valid_o  (inj_valid_o)
  );

  assign ready_o     = run_q;
  assign exam_line_o = run_q;

  // R9
  valid_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    inj_valid_o |-> $past(rd_strobe_i));
endmodule

// File: tb/fp_jump_injector_tb_top.sv
module fp_jump_injector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exam_pulse_i = 1'b0;
  logic [15:0] addr_sw_i = '0;
  logic        rd_strobe_i = 1'b0;
  logic        ready_o, exam_line_o, inj_valid_o;
  logic [7:0]  inj_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [7:0] exp_q [$];
  logic       prev_v = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_jump_injector dut_i (
    .clk(clk), .rst(rst), .exam_pulse_i(exam_pulse_i), .addr_sw_i(addr_sw_i),
    .rd_strobe_i(rd_strobe_i), .ready_o(ready_o), .exam_line_o(exam_line_o),
    .inj_data_o(inj_data_o), .inj_valid_o(inj_valid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pop the queued byte when a new injected beat starts
  always @(negedge clk) begin
    if (!rst) begin
      if (inj_valid_o && !prev_v) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected beat", {8'h0, inj_data_o}, 16'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(inj_data_o == e, "R4/R5/R6 scoreboard byte", {8'h0, inj_data_o}, {8'h0, e});
        end
      end
      prev_v = inj_valid_o;
    end
  end

  task automatic pulse_exam();
    @(negedge clk); #1 exam_pulse_i = 1'b1;
    @(negedge clk); #1 exam_pulse_i = 1'b0;
  endtask

  // One processor read cycle; exp_on says whether a byte should be injected
  task automatic read_beat(input bit exp_on, input logic [7:0] exp, input int hold, input string tag);
    @(negedge clk); #1 rd_strobe_i = 1'b1;
    if (exp_on) exp_q.push_back(exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (exp_on)
        check(inj_valid_o && inj_data_o == exp, {tag, " R7 held byte"}, {7'h0, inj_valid_o, inj_data_o}, {8'h01, exp});
      else
        check(!inj_valid_o && inj_data_o == 8'hFF, {tag, " R9 released"}, {7'h0, inj_valid_o, inj_data_o}, 16'h00FF);
    end
    #1 rd_strobe_i = 1'b0;
    @(negedge clk);
    check(!inj_valid_o && inj_data_o == 8'hFF, {tag, " R9 after strobe"}, {7'h0, inj_valid_o, inj_data_o}, 16'h00FF);
  endtask

  task automatic full_seq(input logic [15:0] sw, input bit poke_mid);
    #1 addr_sw_i = sw;
    pulse_exam();
    check(ready_o && exam_line_o, "R2 ready raised", {14'h0, ready_o, exam_line_o}, 16'h3);
    read_beat(1'b1, 8'hC3, 2, "R4");
    if (poke_mid) begin
      pulse_exam();
      check(ready_o, "R10 ready kept", {15'h0, ready_o}, 16'h1);
    end
    read_beat(1'b1, ~sw[7:0], 1, "R5");
    check(ready_o, "R7 ready mid", {15'h0, ready_o}, 16'h1);
    read_beat(1'b1, ~sw[15:8], 3, "R6");
    check(!ready_o && !exam_line_o, "R8 ready dropped", {14'h0, ready_o, exam_line_o}, 16'h0);
    read_beat(1'b0, 8'hFF, 1, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!ready_o && !exam_line_o, "R1 ready idle", {14'h0, ready_o, exam_line_o}, 16'h0);
    check(!inj_valid_o && inj_data_o == 8'hFF, "R1 data idle", {7'h0, inj_valid_o, inj_data_o}, 16'h00FF);

    read_beat(1'b0, 8'hFF, 2, "R9 idle read");

    // R3: examine while the bus is busy
    @(negedge clk); #1 rd_strobe_i = 1'b1; exam_pulse_i = 1'b1;
    @(negedge clk); #1 exam_pulse_i = 1'b0;
    @(negedge clk);
    check(!ready_o, "R3 busy bus ignored", {15'h0, ready_o}, 16'h0);
    #1 rd_strobe_i = 1'b0;
    @(negedge clk);
    check(!ready_o, "R3 still idle", {15'h0, ready_o}, 16'h0);

    full_seq(16'h0000, 1'b0);
    full_seq(16'hFFFF, 1'b1);
    full_seq(16'h3CA5, 1'b1);
    full_seq(16'h8001, 1'b0);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R9 scoreboard drained", 16'(exp_q.size()), 16'h0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule